// File: doc/BRIEF.md
# Caption Line Waveform Generator

The block produces the digital luma samples of a caption data line for an interlaced 525-line raster. A sync generator elsewhere supplies the current line number and the sample position within the line. On the caption line of the first field (line 21) or of the second field (line 284), when that field is enabled, the block emits a synchronising burst, three framing bits and two 7-bit characters, each character followed by a parity bit. On every other line it emits blanking level. A downstream mixer uses the valid flag to pick these samples instead of the picture samples.

A host loads four character registers through a simple write port. Writes land in shadow copies. Each vertical sync pulse copies all four shadows into the copies the waveform uses, so a caption line never shows a mix of old and new characters. Bit timing comes from a fractional accumulator that steps by the number of bits per line every sample, so that bit edges stay locked to the line length without drift.

The sequencer is a five-state machine. `ST_IDLE` moves to `ST_RUNIN` when the sample position equals the payload offset on an enabled caption line. `ST_RUNIN` moves to `ST_START` after seven bit periods. `ST_START` moves to `ST_CHAR1` after three bit periods. `ST_CHAR1` moves to `ST_CHAR2` after eight bit periods. `ST_CHAR2` returns to `ST_IDLE` after eight bit periods. In every state other than `ST_IDLE`, each transition happens on a bit tick of the accumulator.

Top module: `cc_line21_inserter`

## Requirements
- R1: After reset `cc_valid` is 0, `cc_sample` is the blanking code 256, and all four active characters are 0 until the first vertical sync.
- R2: `cap_mode` bit 0 enables line 21 and bit 1 enables line 284 (00 = none, 11 = both). On any other line, or on a line that is not enabled, `cc_valid` stays 0 and `cc_sample` stays 256.
- R3: `cc_valid` rises in the cycle after the one in which `hpos` equals PAYLOAD_START (130). It then stays high for ceil(26·858/32) = 698 consecutive cycles.
- R4: Payload sample n (n = 0 for the first valid cycle) belongs to bit floor(32·n/858). Bits 0–6 are the run-in, bits 7–9 are the framing bits, bits 10–17 are character 1 plus its parity, and bits 18–25 are character 2 plus its parity.
- R5: During the run-in, with phase p = (32·n) mod 858 and q = 214, the sample is 393 for p < q, 531 for p < 2q, 393 for p < 3q, and 256 otherwise.
- R6: The framing bits are 0, 0, 1.
- R7: Character bits are sent LSB first and are followed by an odd parity bit over the 7 bits. A 1 bit is 531 (50 IRE above blanking) and a 0 bit is 256.
- R8: Write address 0 holds character 1 and address 1 holds character 2 of line 21. Addresses 2 and 3 hold characters 1 and 2 of line 284.
- R9: A host write has no effect on the waveform until the next `vsync_pulse`. A write made in the same cycle as `vsync_pulse` waits for the following pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Shadow register write strobe |
| host_addr | input | 2 | Character register select |
| host_data | input | 7 | Character code |
| cap_mode | input | 2 | Per-field caption enable |
| vsync_pulse | input | 1 | One-cycle vertical sync, copies shadows to active |
| line_num | input | 10 | Current line number (1-based) |
| hpos | input | 10 | Sample index within the line, 0 at sync leading edge |
| cc_sample | output | 10 | Caption luma code |
| cc_valid | output | 1 | High while caption samples are emitted |

## Verification
Each line is swept over every sample position. The bench checks each sample against a model built from the bit and phase formulas. This covers run-in quarter-phase placement and fractional bit edges separately from data content. The character set includes all-ones (parity 0), sparse and alternating codes, so bit-order or parity faults show up as level mismatches. A table walks all four mode values across lines 21, 284 and neighbouring lines, which separates field gating from line decoding. Directed sequences check zeros after reset, writes that stay hidden before a vsync, and a write that coincides with vsync.

// File: rtl/cc_pkg.sv
package cc_pkg;

    localparam int CHAR_W     = 7;
    localparam int NUM_CHARS  = 4;
    localparam int CNT_W      = 3;
    localparam int RUNIN_BITS = 7;
    localparam int FRAME_BITS = 3;
    localparam int SLOT_BITS  = CHAR_W + 1;
    localparam int TOTAL_BITS = RUNIN_BITS + FRAME_BITS + 2 * SLOT_BITS;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RUNIN,
        ST_START,
        ST_CHAR1,
        ST_CHAR2
    } cc_state_e;

    function automatic logic odd_parity(input logic [CHAR_W-1:0] c);
        return ~(^c);
    endfunction

endpackage

// File: rtl/cc_char_bank.sv
module cc_char_bank #(
    parameter int CHAR_W    = 7,
    parameter int NUM_CHARS = 4,
    localparam int ADDR_W   = $clog2(NUM_CHARS)
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [ADDR_W-1:0]           wr_addr,
    input  logic [CHAR_W-1:0]           wr_data,
    input  logic                        load,
    output logic [NUM_CHARS*CHAR_W-1:0] act_flat
);

    for (genvar i = 0; i < NUM_CHARS; i++) begin : g_slot
        logic [CHAR_W-1:0] shadow_q;
        logic [CHAR_W-1:0] active_q;

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                shadow_q <= '0;
            end else if (wr_en && wr_addr == ADDR_W'(i)) begin
                shadow_q <= wr_data;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                active_q <= '0;
            end else if (load) begin
                active_q <= shadow_q;
            end
        end

        assign act_flat[i*CHAR_W +: CHAR_W] = active_q;
    end

endmodule

// File: rtl/cc_bit_clock.sv
module cc_bit_clock #(
    parameter int LINE_SAMPLES  = 858,
    parameter int BITS_PER_LINE = 32,
    localparam int ACC_W        = $clog2(LINE_SAMPLES + BITS_PER_LINE)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             run,
    output logic [ACC_W-1:0] acc,
    output logic             tick
);

    logic [ACC_W-1:0] acc_q;
    logic [ACC_W:0]   sum;

    always_comb begin
        sum  = {1'b0, acc_q} + (ACC_W+1)'(BITS_PER_LINE);
        tick = run && (sum >= (ACC_W+1)'(LINE_SAMPLES));
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            acc_q <= '0;
        end else if (run) begin
            if (tick) begin
                acc_q <= ACC_W'(sum - (ACC_W+1)'(LINE_SAMPLES));
            end else begin
                acc_q <= sum[ACC_W-1:0];
            end
        end
    end

    assign acc = acc_q;

endmodule

// File: rtl/cc_sequencer.sv
module cc_sequencer
    import cc_pkg::*;
#(
    parameter int LINE_SAMPLES = 858,
    parameter int ACC_W        = 10,
    parameter int SAMPLE_W     = 10,
    parameter int BLANK_LVL    = 256,
    parameter int HIGH_LVL     = 531
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic                start_sel,
    input  logic                tick,
    input  logic [ACC_W-1:0]    acc,
    input  logic [CHAR_W-1:0]   f1_c1,
    input  logic [CHAR_W-1:0]   f1_c2,
    input  logic [CHAR_W-1:0]   f2_c1,
    input  logic [CHAR_W-1:0]   f2_c2,
    output logic                busy,
    output logic [SAMPLE_W-1:0] sample,
    output logic                valid
);

    localparam int MID_LVL = (BLANK_LVL + HIGH_LVL) / 2;
    localparam logic [ACC_W-1:0] Q1 = ACC_W'(LINE_SAMPLES / 4);
    localparam logic [ACC_W-1:0] Q2 = ACC_W'(2 * (LINE_SAMPLES / 4));
    localparam logic [ACC_W-1:0] Q3 = ACC_W'(3 * (LINE_SAMPLES / 4));
    localparam logic [SAMPLE_W-1:0] LVL_BLANK = SAMPLE_W'(BLANK_LVL);
    localparam logic [SAMPLE_W-1:0] LVL_MID   = SAMPLE_W'(MID_LVL);
    localparam logic [SAMPLE_W-1:0] LVL_HIGH  = SAMPLE_W'(HIGH_LVL);

    cc_state_e        state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             sel_q;
    logic [CHAR_W-1:0] cur_char;
    logic [SLOT_BITS-1:0] slot;
    logic             bit_val;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            sel_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            if (start && state_q == ST_IDLE) begin
                sel_q <= start_sel;
            end
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    state_d = ST_RUNIN;
                    cnt_d   = '0;
                end
            end
            ST_RUNIN: begin
                if (tick) begin
                    if (cnt_q == CNT_W'(RUNIN_BITS - 1)) begin
                        state_d = ST_START;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            end
            ST_START: begin
                if (tick) begin
                    if (cnt_q == CNT_W'(FRAME_BITS - 1)) begin
                        state_d = ST_CHAR1;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            end
            ST_CHAR1: begin
                if (tick) begin
                    if (cnt_q == CNT_W'(SLOT_BITS - 1)) begin
                        state_d = ST_CHAR2;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            end
            ST_CHAR2: begin
                if (tick) begin
                    if (cnt_q == CNT_W'(SLOT_BITS - 1)) begin
                        state_d = ST_IDLE;
                        cnt_d   = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
            end
        endcase
    end

    // output logic
    always_comb begin
        if (state_q == ST_CHAR1) begin
            cur_char = sel_q ? f2_c1 : f1_c1;
        end else begin
            cur_char = sel_q ? f2_c2 : f1_c2;
        end
        slot    = {odd_parity(cur_char), cur_char};
        bit_val = slot[cnt_q];
        busy    = (state_q != ST_IDLE);
        valid   = 1'b0;
        sample  = LVL_BLANK;
        unique case (state_q)
            ST_IDLE: begin
                valid  = 1'b0;
                sample = LVL_BLANK;
            end
            ST_RUNIN: begin
                valid = 1'b1;
                if (acc < Q1) begin
                    sample = LVL_MID;
                end else if (acc < Q2) begin
                    sample = LVL_HIGH;
                end else if (acc < Q3) begin
                    sample = LVL_MID;
                end else begin
                    sample = LVL_BLANK;
                end
            end
            ST_START: begin
                valid  = 1'b1;
                sample = (cnt_q == CNT_W'(FRAME_BITS - 1)) ? LVL_HIGH : LVL_BLANK;
            end
            ST_CHAR1, ST_CHAR2: begin
                valid  = 1'b1;
                sample = bit_val ? LVL_HIGH : LVL_BLANK;
            end
        endcase
    end

endmodule

// File: rtl/cc_line21_inserter.sv
module cc_line21_inserter
    import cc_pkg::*;
#(
    parameter int LINE_SAMPLES  = 858,
    parameter int BITS_PER_LINE = 32,
    parameter int PAYLOAD_START = 130,
    parameter int F1_LINE       = 21,
    parameter int F2_LINE       = 284,
    parameter int LINE_W        = 10,
    parameter int SAMPLE_W      = 10,
    parameter int BLANK_LVL     = 256,
    parameter int HIGH_LVL      = 531,
    localparam int HPOS_W       = $clog2(LINE_SAMPLES),
    localparam int ADDR_W       = $clog2(NUM_CHARS),
    localparam int ACC_W        = $clog2(LINE_SAMPLES + BITS_PER_LINE)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                host_wr,
    input  logic [ADDR_W-1:0]   host_addr,
    input  logic [CHAR_W-1:0]   host_data,
    input  logic [1:0]          cap_mode,
    input  logic                vsync_pulse,
    input  logic [LINE_W-1:0]   line_num,
    input  logic [HPOS_W-1:0]   hpos,
    output logic [SAMPLE_W-1:0] cc_sample,
    output logic                cc_valid
);

    logic [NUM_CHARS*CHAR_W-1:0] act_flat;
    logic                        on_f1, on_f2, line_hit, start, busy;
    logic                        tick;
    logic [ACC_W-1:0]            acc;

    always_comb begin
        on_f1    = (line_num == LINE_W'(F1_LINE)) && cap_mode[0];
        on_f2    = (line_num == LINE_W'(F2_LINE)) && cap_mode[1];
        line_hit = on_f1 || on_f2;
        start    = line_hit && !busy && (hpos == HPOS_W'(PAYLOAD_START));
    end

    cc_char_bank #(
        .CHAR_W   (CHAR_W),
        .NUM_CHARS(NUM_CHARS)
    ) i_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (host_wr),
        .wr_addr (host_addr),
        .wr_data (host_data),
        .load    (vsync_pulse),
        .act_flat(act_flat)
    );

    cc_bit_clock #(
        .LINE_SAMPLES (LINE_SAMPLES),
        .BITS_PER_LINE(BITS_PER_LINE)
    ) i_clock (
        .clk  (clk),
        .rst_n(rst_n),
        .clear(start),
        .run  (busy),
        .acc  (acc),
        .tick (tick)
    );

    cc_sequencer #(
        .LINE_SAMPLES(LINE_SAMPLES),
        .ACC_W       (ACC_W),
        .SAMPLE_W    (SAMPLE_W),
        .BLANK_LVL   (BLANK_LVL),
        .HIGH_LVL    (HIGH_LVL)
    ) i_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .start_sel(on_f2),
        .tick     (tick),
        .acc      (acc),
        .f1_c1    (act_flat[0*CHAR_W +: CHAR_W]),
        .f1_c2    (act_flat[1*CHAR_W +: CHAR_W]),
        .f2_c1    (act_flat[2*CHAR_W +: CHAR_W]),
        .f2_c2    (act_flat[3*CHAR_W +: CHAR_W]),
        .busy     (busy),
        .sample   (cc_sample),
        .valid    (cc_valid)
    );

endmodule

// File: rtl/cc_inserter_chk.sv
module cc_inserter_chk #(
    parameter int LINE_SAMPLES  = 858,
    parameter int BITS_PER_LINE = 32,
    parameter int PAYLOAD_START = 130,
    parameter int F1_LINE       = 21,
    parameter int F2_LINE       = 284,
    parameter int LINE_W        = 10,
    parameter int SAMPLE_W      = 10,
    parameter int BLANK_LVL     = 256,
    parameter int HIGH_LVL      = 531,
    parameter int HPOS_W        = 10,
    parameter int FLAT_W        = 28
) (
    input logic                clk,
    input logic                rst_n,
    input logic [1:0]          cap_mode,
    input logic                vsync_pulse,
    input logic [LINE_W-1:0]   line_num,
    input logic [HPOS_W-1:0]   hpos,
    input logic [FLAT_W-1:0]   act_flat,
    input logic [SAMPLE_W-1:0] cc_sample,
    input logic                cc_valid
);

    localparam int MID_LVL     = (BLANK_LVL + HIGH_LVL) / 2;
    localparam int PAYLOAD_LEN = (26 * LINE_SAMPLES + BITS_PER_LINE - 1) / BITS_PER_LINE;
    localparam int LEN_W       = $clog2(LINE_SAMPLES + 1);

    logic [LEN_W-1:0] run_len_q;

    always_ff @(posedge clk) begin
        if (!rst_n || !cc_valid) begin
            run_len_q <= '0;
        end else begin
            run_len_q <= run_len_q + 1'b1;
        end
    end

    // R2
    idle_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cc_valid |-> cc_sample == SAMPLE_W'(BLANK_LVL));

    // R5
    level_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cc_valid |-> (cc_sample == SAMPLE_W'(BLANK_LVL) ||
                      cc_sample == SAMPLE_W'(MID_LVL) ||
                      cc_sample == SAMPLE_W'(HIGH_LVL)));

    // R3
    start_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cc_valid) |-> $past(hpos) == HPOS_W'(PAYLOAD_START));

    // R2
    line_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cc_valid) |-> (($past(line_num) == LINE_W'(F1_LINE) && $past(cap_mode[0])) ||
                             ($past(line_num) == LINE_W'(F2_LINE) && $past(cap_mode[1]))));

    // R3
    length_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cc_valid) |-> $past(run_len_q) == LEN_W'(PAYLOAD_LEN - 1));

    // R9
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !vsync_pulse |=> $stable(act_flat));

endmodule

bind cc_line21_inserter cc_inserter_chk #(
    .LINE_SAMPLES (LINE_SAMPLES),
    .BITS_PER_LINE(BITS_PER_LINE),
    .PAYLOAD_START(PAYLOAD_START),
    .F1_LINE      (F1_LINE),
    .F2_LINE      (F2_LINE),
    .LINE_W       (LINE_W),
    .SAMPLE_W     (SAMPLE_W),
    .BLANK_LVL    (BLANK_LVL),
    .HIGH_LVL     (HIGH_LVL),
    .HPOS_W       (HPOS_W),
    .FLAT_W       (cc_pkg::NUM_CHARS * cc_pkg::CHAR_W)
) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cap_mode   (cap_mode),
    .vsync_pulse(vsync_pulse),
    .line_num   (line_num),
    .hpos       (hpos),
    .act_flat   (act_flat),
    .cc_sample  (cc_sample),
    .cc_valid   (cc_valid)
);

// File: tb/test_cc_line21_inserter.sv
`timescale 1ns/1ps
module test_cc_line21_inserter;

    localparam int LINE  = 858;
    localparam int BPL   = 32;
    localparam int START = 130;
    localparam int PLEN  = (26 * LINE + BPL - 1) / BPL;
    localparam int QTR   = LINE / 4;
    localparam int BLANK = 256;
    localparam int HIGH  = 531;
    localparam int MID   = (BLANK + HIGH) / 2;

    // {line[9:0], mode[1:0], expect_valid}
    localparam logic [12:0] VEC [10] = '{
        {10'd21,  2'b01, 1'b1},
        {10'd284, 2'b01, 1'b0},
        {10'd21,  2'b10, 1'b0},
        {10'd284, 2'b10, 1'b1},
        {10'd21,  2'b11, 1'b1},
        {10'd284, 2'b11, 1'b1},
        {10'd21,  2'b00, 1'b0},
        {10'd284, 2'b00, 1'b0},
        {10'd22,  2'b11, 1'b0},
        {10'd20,  2'b11, 1'b0}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_wr = 1'b0;
    logic [1:0] host_addr = '0;
    logic [6:0] host_data = '0;
    logic [1:0] cap_mode = '0;
    logic       vsync_pulse = 1'b0;
    logic [9:0] line_num = '0;
    logic [9:0] hpos = '0;
    logic [9:0] cc_sample;
    logic       cc_valid;

    int  n_checks = 0;
    int  n_fails  = 0;
    bit  finished = 1'b0;

    always #4 clk = ~clk;

    cc_line21_inserter i_cc_line21_inserter (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
        .host_data(host_data), .cap_mode(cap_mode), .vsync_pulse(vsync_pulse),
        .line_num(line_num), .hpos(hpos), .cc_sample(cc_sample), .cc_valid(cc_valid)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // R4: sample n sits in bit floor(32n/LINE); R5 run-in, R6 framing, R7 characters
    function automatic int model(input int n, input logic [6:0] c1, input logic [6:0] c2);
        int b, p;
        logic [7:0] s;
        b = (BPL * n) / LINE;
        p = (BPL * n) % LINE;
        if (b < 7) begin
            if (p < QTR) return MID;
            if (p < 2 * QTR) return HIGH;
            if (p < 3 * QTR) return MID;
            return BLANK;
        end
        if (b < 10) return (b == 9) ? HIGH : BLANK;
        if (b < 18) s = {~(^c1), c1};
        else s = {~(^c2), c2};
        return s[(b - 10) % 8] ? HIGH : BLANK;
    endfunction

    function automatic string region(input int n, input bit en);
        int b;
        if (!en || n < 0 || n >= PLEN) return "R2";
        b = (BPL * n) / LINE;
        if (b < 7) return "R5 R4";
        if (b < 10) return "R6 R4";
        return "R7 R4";
    endfunction

    task automatic run_line(input int ln, input logic [1:0] md, input bit en,
                            input logic [6:0] c1, input logic [6:0] c2, input string tag);
        int bad = 0, vcnt = 0, fa = 0, fe = 0;
        string freq = "";
        line_num = 10'(ln);
        cap_mode = md;
        for (int h = 0; h < LINE; h++) begin
            int n, es;
            bit ev;
            hpos = 10'(h);
            @(negedge clk);
            n  = h - START;
            ev = en && n >= 0 && n < PLEN;
            es = ev ? model(n, c1, c2) : BLANK;
            if (cc_valid) vcnt++;
            if (cc_valid !== ev || int'(cc_sample) != es) begin
                if (bad == 0) begin
                    fa = int'(cc_sample); fe = es; freq = region(n, en);
                    if (cc_valid !== ev) freq = en ? "R3" : "R2";
                end
                bad++;
            end
        end
        hpos = '0;
        check(bad == 0, {tag, " ", freq, " samples"}, fa, fe);
        check(vcnt == (en ? PLEN : 0), {tag, en ? " R3" : " R2", " valid length"},
              vcnt, en ? PLEN : 0);
    endtask

    task automatic host_write(input logic [1:0] a, input logic [6:0] d, input bit with_vs);
        host_wr = 1'b1; host_addr = a; host_data = d; vsync_pulse = with_vs;
        @(negedge clk);
        host_wr = 1'b0; vsync_pulse = 1'b0;
    endtask

    task automatic vsync();
        vsync_pulse = 1'b1;
        @(negedge clk);
        vsync_pulse = 1'b0;
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state at the ports
        check(cc_valid == 1'b0, "R1 valid after reset", int'(cc_valid), 0);
        check(cc_sample == 10'd256, "R1 sample after reset", int'(cc_sample), BLANK);
        // R1: active characters cleared, parity of zero is 1
        run_line(21, 2'b11, 1'b1, 7'h00, 7'h00, "R1 zero chars");

        // R8: address map 0/1 line 21, 2/3 line 284
        host_write(2'd0, 7'h41, 1'b0);
        host_write(2'd1, 7'h00, 1'b0);
        host_write(2'd2, 7'h55, 1'b0);
        host_write(2'd3, 7'h2A, 1'b0);
        // R9: no effect before vsync
        run_line(21, 2'b11, 1'b1, 7'h00, 7'h00, "R9 hidden before vsync");
        run_line(284, 2'b11, 1'b1, 7'h00, 7'h00, "R9 hidden before vsync");
        // R9: write coincident with vsync waits for the next pulse
        host_write(2'd1, 7'h7F, 1'b1);
        run_line(21, 2'b01, 1'b1, 7'h41, 7'h00, "R9 same-cycle write");
        vsync();
        run_line(21, 2'b01, 1'b1, 7'h41, 7'h7F, "R9 after second vsync");
        run_line(284, 2'b10, 1'b1, 7'h55, 7'h2A, "R8 field two chars");

        // R2 R8: mode and line table
        foreach (VEC[i]) begin
            int ln;
            ln = int'(VEC[i][12:3]);
            run_line(ln, VEC[i][2:1], VEC[i][0],
                     (ln == 284) ? 7'h55 : 7'h41, (ln == 284) ? 7'h2A : 7'h7F,
                     "R2 R8 table");
        end

        // R3: caption must not start when hpos skips the offset
        line_num = 10'd21; cap_mode = 2'b11; hpos = 10'(START + 1);
        repeat (3) @(negedge clk);
        check(cc_valid == 1'b0, "R3 no start off offset", int'(cc_valid), 0);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

endmodule